// File: doc/BRIEF.md
# Indirect Configuration and I/O Access Port

This block sits between a CPU register bus and a downstream configuration/I/O request port. Software first writes a 32-bit target address into an address register, then reads or writes one of two data windows. An access to the configuration data window becomes a configuration-space request. An access to the I/O data window becomes an I/O-space request. In both cases the request uses the stored address, with its two low bits cleared, plus the byte lane of the window access.

Each CPU access is a one-cycle `req_i` pulse carrying offset, size code and write data. The block checks the offset and size pair. A rejected access completes one cycle later with an error flag and touches no state. A local register access also completes one cycle later. A window access raises a downstream request, holds it until `dn_ack_i`, and completes on the cycle after that acknowledge. The block also holds two small side registers: a 2-bit fast-transfer enable field and a trap-vector address register with fixed bits. The requester must not issue a new `req_i` before `ack_o`; a request that arrives while a window access is in flight is dropped.

Size code on `size_i` and `dn_size_o`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal. Word offsets (default parameters): address register 0x00, configuration window 0x04, I/O window 0x08, fast-transfer enable 0x0C, trap-vector register 0x10. Data on `wdata_i` and `rdata_o` is right-justified.

Top module: `ipc_port`

## Requirements
- R1: After reset `ack_o` and `dn_req_o` are low. The address register and the fast-transfer field read 0. The trap-vector register reads 0xFFFA0030.
- R2: The address register, the fast-transfer field and the trap-vector register accept only 4-byte accesses at byte lane 0. Any other size at those words is rejected.
- R3: A write to the address register stores all 32 bits, and a read returns them exactly, including bits [1:0].
- R4: A configuration window access at lane k (0..3) drives `dn_addr_o` = (stored address with bits [1:0] cleared) OR k and `dn_space_o`=0. It is forwarded whatever the value of bit 31 of the address.
- R5: An I/O window access at lane k drives `dn_addr_o` = (stored address with bits [1:0] cleared) + k and `dn_space_o`=1. `dn_size_o` and `dn_we_o` follow the CPU access.
- R6: For configuration accesses, the N access bytes are byte-reversed in both directions between the CPU side and the downstream side. For I/O accesses they pass unchanged. Only the low N bytes are carried, and the upper bytes are zero. A successful write completes with `rdata_o`=0.
- R7: Window validity. The I/O window allows lane 0 with any size, lane 2 with 1 or 2 bytes, and lanes 1 and 3 with 1 byte only. The configuration window allows any access with k+N <= 4.
- R8: A write to the fast-transfer field keeps only write-data bits [1:0].
- R9: A write of value v to the trap-vector register stores 0xFFFA0030 | (v & 0x0001E000).
- R10: A rejected access completes with `ack_o`=1, `err_o`=1 and `rdata_o`=0xFFFFFFFF on the cycle after `req_i`. It raises no downstream request and changes no register. Unmapped words and size code 3 are rejected.
- R11: `dn_req_o` rises the cycle after `req_i` and holds with stable address, data, size, space and direction until `dn_ack_i` is sampled high. It then falls, and `ack_o` pulses in that same following cycle. `ack_o` stays low while a request is pending.
- R12: A valid local register access completes with a one-cycle `ack_o` pulse and `err_o`=0 on the cycle after `req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle CPU access strobe |
| we_i | input | 1 | 1 = write |
| ofs_i | input | OFS_W | Byte offset of the access |
| size_i | input | 2 | Size code (0:1B, 1:2B, 2:4B, 3:illegal) |
| wdata_i | input | 32 | Right-justified write data |
| ack_o | output | 1 | Access complete pulse |
| err_o | output | 1 | Access rejected (with ack_o) |
| rdata_o | output | 32 | Right-justified read data |
| dn_req_o | output | 1 | Downstream request, held until acknowledged |
| dn_space_o | output | 1 | 0 = configuration, 1 = I/O |
| dn_we_o | output | 1 | Downstream write |
| dn_size_o | output | 2 | Downstream size code |
| dn_addr_o | output | 32 | Downstream target address |
| dn_wdata_o | output | 32 | Downstream write data |
| dn_ack_i | input | 1 | Downstream acknowledge |
| dn_rdata_i | input | 32 | Downstream read data, valid with dn_ack_i |

## Verification
The bench builds the block with its default parameters: a 5-bit offset, the five word offsets listed above, a 2-bit fast-transfer field and the default trap-vector constants. With these values every legal and illegal lane/size pair of both windows is reachable. So are the unmapped word 0x14 and the fixed-bit behaviour of the trap-vector register. Downstream latencies of zero to several cycles test that the request stays held and that the CPU response is stalled.

// File: rtl/ipc_port_pkg.sv
package ipc_port_pkg;
  localparam logic [1:0] SZ_1 = 2'd0;
  localparam logic [1:0] SZ_2 = 2'd1;
  localparam logic [1:0] SZ_4 = 2'd2;
  localparam logic [1:0] SZ_X = 2'd3;

  typedef enum logic [2:0] {
    T_NONE, T_CADDR, T_CDATA, T_IODATA, T_FBB, T_TOC
  } tgt_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_1:    return 3'd1;
      SZ_2:    return 3'd2;
      SZ_4:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_2:    return 32'h0000_FFFF;
      SZ_4:    return 32'hFFFF_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [31:0] lane_swap(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      SZ_2:    return {16'h0, d[7:0], d[15:8]};
      SZ_4:    return {d[7:0], d[15:8], d[23:16], d[31:24]};
      default: return {24'h0, d[7:0]};
    endcase
  endfunction
endpackage

// File: rtl/ipc_decode.sv
module ipc_decode
  import ipc_port_pkg::*;
#(
  parameter int unsigned OFS_W     = 5,
  parameter int unsigned CADDR_OFS = 'h00,
  parameter int unsigned CDATA_OFS = 'h04,
  parameter int unsigned IODAT_OFS = 'h08,
  parameter int unsigned FBB_OFS   = 'h0C,
  parameter int unsigned TOC_OFS   = 'h10
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [1:0]       size_i,
  output tgt_e             tgt_o,
  output logic [1:0]       lane_o,
  output logic             valid_o
);
  localparam int unsigned WORD_W = OFS_W - 2;

  logic [WORD_W-1:0] word;
  logic [1:0]        lane;
  logic [3:0]        span;

  assign word   = ofs_i[OFS_W-1:2];
  assign lane   = ofs_i[1:0];
  assign lane_o = lane;
  assign span   = {2'b00, lane} + {1'b0, size_bytes(size_i)};

  always_comb begin
    tgt_o = T_NONE;
    if      (word == WORD_W'(CADDR_OFS >> 2)) tgt_o = T_CADDR;
    else if (word == WORD_W'(CDATA_OFS >> 2)) tgt_o = T_CDATA;
    else if (word == WORD_W'(IODAT_OFS >> 2)) tgt_o = T_IODATA;
    else if (word == WORD_W'(FBB_OFS   >> 2)) tgt_o = T_FBB;
    else if (word == WORD_W'(TOC_OFS   >> 2)) tgt_o = T_TOC;
  end

  always_comb begin
    valid_o = 1'b0;
    unique case (tgt_o)
      T_CADDR, T_FBB, T_TOC: valid_o = (size_i == SZ_4) && (lane == 2'd0);
      T_CDATA:               valid_o = (size_i != SZ_X) && (span <= 4'd4);
      T_IODATA: begin
        unique case (lane)
          2'd0:    valid_o = (size_i != SZ_X);
          2'd2:    valid_o = (size_i == SZ_1) || (size_i == SZ_2);
          default: valid_o = (size_i == SZ_1);
        endcase
      end
      default:               valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipc_regs.sv
module ipc_regs
  import ipc_port_pkg::*;
#(
  parameter int unsigned FBB_W    = 2,
  parameter logic [31:0] TOC_BASE = 32'hFFFA_0030,
  parameter logic [31:0] TOC_KEEP = 32'h0001_E000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  tgt_e             tgt_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      caddr_o,
  output logic [FBB_W-1:0] fbb_o,
  output logic [31:0]      toc_o
);
  logic caddr_we, fbb_we, toc_we;

  assign caddr_we = wr_i && (tgt_i == T_CADDR);
  assign fbb_we   = wr_i && (tgt_i == T_FBB);
  assign toc_we   = wr_i && (tgt_i == T_TOC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      caddr_o <= '0;
      fbb_o   <= '0;
      toc_o   <= TOC_BASE;
    end else begin
      if (caddr_we) caddr_o <= wdata_i;
      if (fbb_we)   fbb_o   <= wdata_i[FBB_W-1:0];
      if (toc_we)   toc_o   <= TOC_BASE | (wdata_i & TOC_KEEP);
    end
  end

  a_r3_caddr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !caddr_we |=> $stable(caddr_o));
  a_r8_fbb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fbb_we |=> $stable(fbb_o));
  a_r9_toc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !toc_we |=> $stable(toc_o));
endmodule

// File: rtl/ipc_xfer.sv
module ipc_xfer
  import ipc_port_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  input  tgt_e        tgt_i,
  input  logic [1:0]  lane_i,
  input  logic        valid_i,
  input  logic [31:0] caddr_i,
  input  logic [31:0] local_rdata_i,
  output logic        local_wr_o,
  output logic        ack_o,
  output logic        err_o,
  output logic [31:0] rdata_o,
  output logic        dn_req_o,
  output logic        dn_space_o,
  output logic        dn_we_o,
  output logic [1:0]  dn_size_o,
  output logic [31:0] dn_addr_o,
  output logic [31:0] dn_wdata_o,
  input  logic        dn_ack_i,
  input  logic [31:0] dn_rdata_i
);
  logic        start, fwd, is_cfg;
  logic [31:0] base, nxt_addr, wd_m, nxt_wdata, rd_m, rd_fmt;

  assign start      = req_i && !dn_req_o;
  assign fwd        = (tgt_i == T_CDATA) || (tgt_i == T_IODATA);
  assign is_cfg     = (tgt_i == T_CDATA);
  assign local_wr_o = start && valid_i && !fwd && we_i;

  assign base      = {caddr_i[31:2], 2'b00};
  assign nxt_addr  = is_cfg ? (base | {30'h0, lane_i}) : (base + {30'h0, lane_i});
  assign wd_m      = wdata_i & size_mask(size_i);
  assign nxt_wdata = is_cfg ? lane_swap(wd_m, size_i) : wd_m;

  // dn_space_o = 0 marks a configuration request
  assign rd_m   = dn_rdata_i & size_mask(dn_size_o);
  assign rd_fmt = dn_space_o ? rd_m : lane_swap(rd_m, dn_size_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      err_o      <= 1'b0;
      rdata_o    <= '0;
      dn_req_o   <= 1'b0;
      dn_space_o <= 1'b0;
      dn_we_o    <= 1'b0;
      dn_size_o  <= SZ_1;
      dn_addr_o  <= '0;
      dn_wdata_o <= '0;
    end else begin
      ack_o <= 1'b0;
      err_o <= 1'b0;
      if (dn_req_o) begin
        if (dn_ack_i) begin
          dn_req_o <= 1'b0;
          ack_o    <= 1'b1;
          rdata_o  <= dn_we_o ? 32'h0 : rd_fmt;
        end
      end else if (start) begin
        if (!valid_i) begin
          ack_o   <= 1'b1;
          err_o   <= 1'b1;
          rdata_o <= '1;
        end else if (fwd) begin
          dn_req_o   <= 1'b1;
          dn_space_o <= !is_cfg;
          dn_we_o    <= we_i;
          dn_size_o  <= size_i;
          dn_addr_o  <= nxt_addr;
          dn_wdata_o <= nxt_wdata;
        end else begin
          ack_o   <= 1'b1;
          rdata_o <= we_i ? 32'h0 : local_rdata_i;
        end
      end
    end
  end

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && !dn_ack_i |=> dn_req_o && $stable(dn_addr_o) && $stable(dn_wdata_o)
                              && $stable(dn_size_o) && $stable(dn_space_o) && $stable(dn_we_o));
  a_r11_no_early_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> !ack_o);
  a_r11_ack_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && dn_ack_i |=> ack_o && !dn_req_o);
  a_r12_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r10_err_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ack_o && (rdata_o == 32'hFFFF_FFFF) && !dn_req_o);
endmodule

// File: rtl/ipc_port.sv
module ipc_port
  import ipc_port_pkg::*;
#(
  parameter int unsigned OFS_W     = 5,
  parameter int unsigned CADDR_OFS = 'h00,
  parameter int unsigned CDATA_OFS = 'h04,
  parameter int unsigned IODAT_OFS = 'h08,
  parameter int unsigned FBB_OFS   = 'h0C,
  parameter int unsigned TOC_OFS   = 'h10,
  parameter int unsigned FBB_W     = 2,
  parameter logic [31:0] TOC_BASE  = 32'hFFFA_0030,
  parameter logic [31:0] TOC_KEEP  = 32'h0001_E000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [1:0]       size_i,
  input  logic [31:0]      wdata_i,
  output logic             ack_o,
  output logic             err_o,
  output logic [31:0]      rdata_o,
  output logic             dn_req_o,
  output logic             dn_space_o,
  output logic             dn_we_o,
  output logic [1:0]       dn_size_o,
  output logic [31:0]      dn_addr_o,
  output logic [31:0]      dn_wdata_o,
  input  logic             dn_ack_i,
  input  logic [31:0]      dn_rdata_i
);
  tgt_e             tgt;
  logic [1:0]       lane;
  logic             valid, local_wr;
  logic [31:0]      caddr, toc, local_rdata;
  logic [FBB_W-1:0] fbb;

  ipc_decode #(
    .OFS_W(OFS_W), .CADDR_OFS(CADDR_OFS), .CDATA_OFS(CDATA_OFS),
    .IODAT_OFS(IODAT_OFS), .FBB_OFS(FBB_OFS), .TOC_OFS(TOC_OFS)
  ) u_decode (
    .ofs_i(ofs_i), .size_i(size_i), .tgt_o(tgt), .lane_o(lane), .valid_o(valid)
  );

  ipc_regs #(
    .FBB_W(FBB_W), .TOC_BASE(TOC_BASE), .TOC_KEEP(TOC_KEEP)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(local_wr), .tgt_i(tgt), .wdata_i(wdata_i),
    .caddr_o(caddr), .fbb_o(fbb), .toc_o(toc)
  );

  always_comb begin
    unique case (tgt)
      T_CADDR: local_rdata = caddr;
      T_FBB:   local_rdata = {{(32-FBB_W){1'b0}}, fbb};
      T_TOC:   local_rdata = toc;
      default: local_rdata = 32'h0;
    endcase
  end

  ipc_xfer u_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .size_i(size_i),
    .wdata_i(wdata_i), .tgt_i(tgt), .lane_i(lane), .valid_i(valid), .caddr_i(caddr),
    .local_rdata_i(local_rdata), .local_wr_o(local_wr),
    .ack_o(ack_o), .err_o(err_o), .rdata_o(rdata_o),
    .dn_req_o(dn_req_o), .dn_space_o(dn_space_o), .dn_we_o(dn_we_o),
    .dn_size_o(dn_size_o), .dn_addr_o(dn_addr_o), .dn_wdata_o(dn_wdata_o),
    .dn_ack_i(dn_ack_i), .dn_rdata_i(dn_rdata_i)
  );

  a_r10_no_fwd_on_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !dn_req_o && !valid |=> !dn_req_o && err_o);
endmodule

// File: tb/ipc_port_tb.sv
`timescale 1ns/1ps
module ipc_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  ofs = '0;
  logic [1:0]  sz = '0;
  logic [31:0] wdata = '0;
  logic        ack, err, dn_req, dn_space, dn_we, dn_ack = 1'b0;
  logic [1:0]  dn_size;
  logic [31:0] rdata, dn_addr, dn_wdata, dn_rdata = '0;

  int vec = 0, bad = 0;
  logic [31:0] m_caddr = 32'h0, m_fbb = 32'h0, m_toc = 32'hFFFA_0030;

  always #2.5 clk = ~clk;

  ipc_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .ofs_i(ofs), .size_i(sz),
    .wdata_i(wdata), .ack_o(ack), .err_o(err), .rdata_o(rdata),
    .dn_req_o(dn_req), .dn_space_o(dn_space), .dn_we_o(dn_we), .dn_size_o(dn_size),
    .dn_addr_o(dn_addr), .dn_wdata_o(dn_wdata), .dn_ack_i(dn_ack), .dn_rdata_i(dn_rdata)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] d, input int n);
    logic [31:0] o = 0;
    for (int i = 0; i < n; i++) o[8*i +: 8] = d[8*(n-1-i) +: 8];
    return o;
  endfunction

  task automatic acc(input string tag, input logic w, input logic [4:0] o, input logic [1:0] s,
                     input logic [31:0] wd, input int lat, input logic [31:0] dn_rd);
    int n, k, word;
    bit ok, fwd, cfg;
    logic [31:0] msk, base, e_addr, e_wd, e_rd;
    n = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 0;
    k = int'(o) % 4;
    word = int'(o) - k;
    cfg = (word == 4);
    fwd = (word == 4) || (word == 8);
    case (word)
      0, 12, 16: ok = (n == 4) && (k == 0);
      4:         ok = (n != 0) && (k + n <= 4);
      8:         ok = (k == 0) ? (n != 0) : (k == 2) ? (n == 1 || n == 2) : (n == 1);
      default:   ok = 0;
    endcase
    msk = (n == 4) ? 32'hFFFF_FFFF : (n == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
    base = m_caddr & ~32'h3;
    e_addr = cfg ? (base | k) : (base + k);
    e_wd = cfg ? rev(wd & msk, n) : (wd & msk);
    e_rd = w ? 32'h0 : (cfg ? rev(dn_rd & msk, n) : (dn_rd & msk));
    dn_rdata = dn_rd;
    @(negedge clk);
    req = 1'b1; we = w; ofs = o; sz = s; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    if (!ok) begin
      chk(tag, "reject ack", {31'h0, ack}, 32'h1);
      chk(tag, "reject err", {31'h0, err}, 32'h1);
      chk(tag, "reject rdata", rdata, 32'hFFFF_FFFF);
      chk(tag, "reject no dn_req", {31'h0, dn_req}, 32'h0);
    end else if (!fwd) begin
      if (w) begin
        case (word)
          0:  m_caddr = wd;
          12: m_fbb = wd & 32'h3;
          default: m_toc = 32'hFFFA_0030 | (wd & 32'h0001_E000);
        endcase
      end
      chk(tag, "local ack", {30'h0, ack, err}, 32'h2);
      chk(tag, "local rdata", rdata,
          w ? 32'h0 : (word == 0) ? m_caddr : (word == 12) ? m_fbb : m_toc);
      chk(tag, "local no dn_req", {31'h0, dn_req}, 32'h0);
    end else begin
      for (int c = 0; c <= lat; c++) begin
        chk(tag, "dn_req held", {31'h0, dn_req}, 32'h1);
        chk(tag, "no early ack", {31'h0, ack}, 32'h0);
        chk(tag, "dn_addr", dn_addr, e_addr);
        chk(tag, "dn_space/we/size", {28'h0, dn_space, dn_we, dn_size}, {28'h0, !cfg, w, s});
        chk(tag, "dn_wdata", dn_wdata, e_wd);
        if (c == lat) dn_ack = 1'b1;
        @(negedge clk);
      end
      dn_ack = 1'b0;
      chk(tag, "fwd ack", {30'h0, ack, err}, 32'h2);
      chk(tag, "fwd rdata", rdata, e_rd);
      chk(tag, "dn_req dropped", {31'h0, dn_req}, 32'h0);
    end
    @(negedge clk);
    chk(tag, "ack pulse", {31'h0, ack}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ack at reset", {31'h0, ack}, 32'h0);
    chk("R1", "dn_req at reset", {31'h0, dn_req}, 32'h0);
    rst_n = 1'b1;
    acc("R1", 0, 5'h00, 2, 0, 0, 0);
    acc("R1", 0, 5'h10, 2, 0, 0, 0);
    acc("R1", 0, 5'h0C, 2, 0, 0, 0);
    acc("R3", 1, 5'h00, 2, 32'h0000_1237, 0, 0);
    acc("R3", 0, 5'h00, 2, 0, 0, 0);
    acc("R2", 1, 5'h00, 1, 32'hDEAD_BEEF, 0, 0);
    acc("R2", 1, 5'h10, 0, 32'hFFFF_FFFF, 0, 0);
    acc("R2", 0, 5'h00, 2, 0, 0, 0);
    acc("R2", 0, 5'h10, 2, 0, 0, 0);
    acc("R4", 0, 5'h04, 2, 0, 0, 32'hA1B2_C3D4);
    acc("R4", 0, 5'h05, 0, 0, 2, 32'h0000_0077);
    acc("R6", 0, 5'h06, 1, 0, 1, 32'h1234_5678);
    acc("R6", 1, 5'h04, 2, 32'h1122_3344, 3, 0);
    acc("R7", 0, 5'h07, 1, 0, 0, 0);
    acc("R7", 1, 5'h05, 2, 32'h1, 0, 0);
    acc("R5", 0, 5'h08, 2, 0, 1, 32'hCAFE_F00D);
    acc("R5", 1, 5'h0A, 1, 32'hFFFF_ABCD, 0, 0);
    acc("R5", 0, 5'h0B, 0, 0, 4, 32'h0000_00E5);
    acc("R7", 0, 5'h09, 1, 0, 0, 0);
    acc("R7", 0, 5'h0A, 2, 0, 0, 0);
    acc("R7", 1, 5'h0B, 1, 32'h5, 0, 0);
    acc("R7", 0, 5'h0A, 0, 0, 0, 32'h0000_0042);
    acc("R4", 1, 5'h00, 2, 32'h8000_00FF, 0, 0);
    acc("R4", 0, 5'h06, 0, 0, 0, 32'h0000_0011);
    acc("R5", 0, 5'h0B, 0, 0, 0, 32'h0000_0022);
    acc("R3", 0, 5'h00, 2, 0, 0, 0);
    acc("R8", 1, 5'h0C, 2, 32'hFFFF_FFFF, 0, 0);
    acc("R8", 0, 5'h0C, 2, 0, 0, 0);
    acc("R9", 1, 5'h10, 2, 32'hFFFF_FFFF, 0, 0);
    acc("R9", 0, 5'h10, 2, 0, 0, 0);
    acc("R9", 1, 5'h10, 2, 32'h0000_A000, 0, 0);
    acc("R9", 0, 5'h10, 2, 0, 0, 0);
    acc("R10", 0, 5'h14, 2, 0, 0, 0);
    acc("R10", 1, 5'h00, 3, 32'h0, 0, 0);
    acc("R10", 1, 5'h04, 3, 32'h0, 0, 0);
    acc("R10", 0, 5'h00, 2, 0, 0, 0);
    acc("R12", 1, 5'h0C, 2, 32'h1, 0, 0);
    acc("R11", 1, 5'h08, 2, 32'h0102_0304, 6, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule